// File: doc/BRIEF.md
# Producer-Consumer Latency Scoreboard

This block tells an issue stage whether a source operand can be read in the current cycle. Each result register is identified by a tag. When an operation issues, the block stores three things against its destination tag: a pending flag, the producer's class and the current value of a free-running cycle counter. A later operation asks about one of its source tags and gives its own consumer class. The block answers ready or not-ready for that cycle.

The wait is not a fixed number per producer. A selector picks the latency from the producer/consumer pair. Some pairs are shorter than the producer's default: chained multiplies and chained matrix operations. Others are longer: results read by condition-register logic. Several query ports read the same table in parallel.

Register values, forwarding and the choice of which operation issues are outside the block. The cycle counter is narrow and wraps. A pending record is retired once it is older than the longest latency in the table, so the subtraction on the counter never sees more than one wrap.

Top module: `dep_lat_scoreboard`

## Requirements
- R1: After a synchronous active-low reset, every tag is untracked and every query reports ready. `cycle_o` reads 0 and then increases by one per clock, modulo 2^CNT_W.
- R2: An issue in cycle t with latency L for the asked consumer makes that tag read not-ready from cycle t+1 through t+L-1 and ready from t+L on. A query in cycle t itself sees the record that existed before the issue.
- R3: Producer codes and their default latencies: 0 simple ALU = 2, 1 record-form shift/rotate or count = 3, 2 load = 4, 4 multiply = 5, 5 record-form multiply = 5, 6 divide = 12, 7 record-form divide = 12, 8 matrix = 9. Codes 10 to 15 take 2. Consumer codes: 0 plain, 1 condition-register reader, 2 multiply, 3 matrix.
- R4: For a condition-register reader (consumer 1), producer 0 waits 4 and producer 1 waits 5.
- R5: For a multiply consumer (2), producers 4 and 5 wait 4. Producer 5 read by consumer 1 waits 7.
- R6: Producer 7 read by consumer 1 waits 14. Producer 6 waits 12 for every consumer.
- R7: Producer 8 read by a matrix consumer (3) waits 4 instead of 9.
- R8: Producer 3 (single-precision FP load) waits 7. Producer 9 (address update of a store-with-update) waits 2. Both apply to every consumer.
- R9: Issuing a tag that already has a record replaces it. The new class and issue cycle decide the answer, whether the new wait ends earlier or later than the old one.
- R10: Once ready, a tag stays ready for the same consumer class until it is issued again, across any number of counter wraps.
- R11: Each of the NQ query ports answers on its own in the same cycle. Different tags or different consumer classes on different ports give their own correct answers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| iss_vld_i | input | 1 | An operation issues this cycle |
| iss_tag_i | input | TAG_W | Destination tag of the issuing operation |
| iss_cls_i | input | 4 | Producer class code (R3) |
| qry_tag_i | input | NQ*TAG_W | Source tag per query port; port q uses bits [q*TAG_W +: TAG_W] |
| qry_cls_i | input | NQ*2 | Consumer class per query port; port q uses bits [2q +: 2] |
| qry_rdy_o | output | NQ | Ready answer per query port, combinational from the query inputs |
| cycle_o | output | CNT_W | Free-running cycle counter |

## Verification
The case of interest is an issue and a query of the same tag in the same cycle. The query must get the old answer, and the new record must take over from the next cycle. The bench provokes this in two places. Every latency measurement queries its own tag in the cycle it is issued. The overwrite sequence reissues a tag that is still pending and also one that is already ready. A reference model keeps exact issue times as integers and predicts each answer, updating the model only after the expectations for that cycle have been queued. A second port queries a different tag or class in the same cycles, and long idle stretches push the narrow counter through many wraps.

// File: rtl/lsb_pkg.sv
package lsb_pkg;

    localparam int PCLS_W = 4;
    localparam int CCLS_W = 2;

    typedef enum logic [PCLS_W-1:0] {
        PK_ALU    = 4'd0,
        PK_ROTREC = 4'd1,
        PK_LOAD   = 4'd2,
        PK_LDSP   = 4'd3,
        PK_MUL    = 4'd4,
        PK_MULREC = 4'd5,
        PK_DIV    = 4'd6,
        PK_DIVREC = 4'd7,
        PK_MMA    = 4'd8,
        PK_STUPD  = 4'd9
    } prod_e;

    typedef enum logic [CCLS_W-1:0] {
        CK_PLAIN = 2'd0,
        CK_CR    = 2'd1,
        CK_MUL   = 2'd2,
        CK_MMA   = 2'd3
    } cons_e;

    // default and pair-specific waits, in cycles
    localparam int LAT_ALU       = 2;
    localparam int LAT_ALU_CR    = 4;
    localparam int LAT_ROT       = 3;
    localparam int LAT_ROT_CR    = 5;
    localparam int LAT_LOAD      = 4;
    localparam int LAT_LDSP      = 7;
    localparam int LAT_MUL       = 5;
    localparam int LAT_MUL_CHAIN = 4;
    localparam int LAT_MULREC_CR = 7;
    localparam int LAT_DIV       = 12;
    localparam int LAT_DIVREC_CR = 14;
    localparam int LAT_MMA       = 9;
    localparam int LAT_MMA_CHAIN = 4;
    localparam int LAT_STUPD     = 2;
    localparam int LAT_OTHER     = 2;

    localparam int LAT_MAX = LAT_DIVREC_CR;
    localparam int LAT_W   = $clog2(LAT_MAX + 1);

endpackage

// File: rtl/lsb_lat_sel.sv
module lsb_lat_sel
    import lsb_pkg::*;
(
    input  logic [PCLS_W-1:0] prod_i,
    input  logic [CCLS_W-1:0] cons_i,
    output logic [LAT_W-1:0]  lat_o
);

    int lat;

    always_comb begin
        lat = LAT_OTHER;
        case (prod_i)
            PK_ALU:    lat = (cons_i == CK_CR)  ? LAT_ALU_CR : LAT_ALU;
            PK_ROTREC: lat = (cons_i == CK_CR)  ? LAT_ROT_CR : LAT_ROT;
            PK_LOAD:   lat = LAT_LOAD;
            PK_LDSP:   lat = LAT_LDSP;
            PK_MUL:    lat = (cons_i == CK_MUL) ? LAT_MUL_CHAIN : LAT_MUL;
            PK_MULREC: begin
                if (cons_i == CK_MUL)     lat = LAT_MUL_CHAIN;
                else if (cons_i == CK_CR) lat = LAT_MULREC_CR;
                else                      lat = LAT_MUL;
            end
            PK_DIV:    lat = LAT_DIV;
            PK_DIVREC: lat = (cons_i == CK_CR)  ? LAT_DIVREC_CR : LAT_DIV;
            PK_MMA:    lat = (cons_i == CK_MMA) ? LAT_MMA_CHAIN : LAT_MMA;
            PK_STUPD:  lat = LAT_STUPD;
            default:   lat = LAT_OTHER;
        endcase
        lat_o = LAT_W'(lat);
    end

endmodule

// File: rtl/lsb_cycle_ctr.sv
module lsb_cycle_ctr #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cyc_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d     = ctr_q;
        ctr_d.cnt = ctr_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign cyc_o = ctr_q.cnt;

    // R1: one step per clock, wrapping
    a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ctr_q.cnt == CNT_W'($past(ctr_q.cnt) + CNT_W'(1)));

endmodule

// File: rtl/lsb_tag_table.sv
module lsb_tag_table
    import lsb_pkg::*;
#(
    parameter int NUM_TAGS = 32,
    parameter int CNT_W    = 6,
    parameter int NQ       = 2,
    localparam int TAG_W   = $clog2(NUM_TAGS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CNT_W-1:0]        cyc_i,
    input  logic                    iss_vld_i,
    input  logic [TAG_W-1:0]        iss_tag_i,
    input  logic [PCLS_W-1:0]       iss_cls_i,
    input  logic [NQ*TAG_W-1:0]     qry_tag_i,
    output logic [NQ-1:0]           rd_pend_o,
    output logic [NQ*PCLS_W-1:0]    rd_cls_o,
    output logic [NQ*CNT_W-1:0]     rd_stamp_o
);

    typedef struct packed {
        logic [NUM_TAGS-1:0]             pend;
        logic [NUM_TAGS-1:0][PCLS_W-1:0] cls;
        logic [NUM_TAGS-1:0][CNT_W-1:0]  stamp;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        logic [CNT_W-1:0] age;
        tbl_d = tbl_q;
        // retire records older than the longest wait so the age never wraps
        for (int i = 0; i < NUM_TAGS; i++) begin
            age = cyc_i - tbl_q.stamp[i];
            if (tbl_q.pend[i] && (age >= CNT_W'(LAT_MAX))) begin
                tbl_d.pend[i] = 1'b0;
            end
        end
        // a new issue wins over retirement of the same tag
        if (iss_vld_i) begin
            tbl_d.pend[iss_tag_i]  = 1'b1;
            tbl_d.cls[iss_tag_i]   = iss_cls_i;
            tbl_d.stamp[iss_tag_i] = cyc_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    for (genvar q = 0; q < NQ; q++) begin : g_rd
        logic [TAG_W-1:0] tag;
        assign tag                            = qry_tag_i[q*TAG_W +: TAG_W];
        assign rd_pend_o[q]                   = tbl_q.pend[tag];
        assign rd_cls_o[q*PCLS_W +: PCLS_W]   = tbl_q.cls[tag];
        assign rd_stamp_o[q*CNT_W +: CNT_W]   = tbl_q.stamp[tag];
    end

    // R1: reset leaves nothing pending
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> tbl_q.pend == '0);

    // R2, R9: an issue writes the record with the issue cycle
    a_r2_issue_record: assert property (@(posedge clk) disable iff (!rst_n)
        iss_vld_i |=> tbl_q.pend[$past(iss_tag_i)] &&
                      tbl_q.stamp[$past(iss_tag_i)] == $past(cyc_i) &&
                      tbl_q.cls[$past(iss_tag_i)] == $past(iss_cls_i));

    for (genvar i = 0; i < NUM_TAGS; i++) begin : g_age_chk
        // R10: a pending record never ages past the longest wait
        a_r10_age_bound: assert property (@(posedge clk) disable iff (!rst_n)
            tbl_q.pend[i] |-> CNT_W'(cyc_i - tbl_q.stamp[i]) <= CNT_W'(LAT_MAX));
    end

endmodule

// File: rtl/dep_lat_scoreboard.sv
module dep_lat_scoreboard
    import lsb_pkg::*;
#(
    parameter int NUM_TAGS = 32,
    parameter int CNT_W    = 6,
    parameter int NQ       = 2,
    localparam int TAG_W   = $clog2(NUM_TAGS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 iss_vld_i,
    input  logic [TAG_W-1:0]     iss_tag_i,
    input  logic [PCLS_W-1:0]    iss_cls_i,
    input  logic [NQ*TAG_W-1:0]  qry_tag_i,
    input  logic [NQ*CCLS_W-1:0] qry_cls_i,
    output logic [NQ-1:0]        qry_rdy_o,
    output logic [CNT_W-1:0]     cycle_o
);

    logic [CNT_W-1:0]     cyc;
    logic [NQ-1:0]        rd_pend;
    logic [NQ*PCLS_W-1:0] rd_cls;
    logic [NQ*CNT_W-1:0]  rd_stamp;

    lsb_cycle_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .cyc_o (cyc)
    );

    lsb_tag_table #(.NUM_TAGS(NUM_TAGS), .CNT_W(CNT_W), .NQ(NQ)) u_tbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_i      (cyc),
        .iss_vld_i  (iss_vld_i),
        .iss_tag_i  (iss_tag_i),
        .iss_cls_i  (iss_cls_i),
        .qry_tag_i  (qry_tag_i),
        .rd_pend_o  (rd_pend),
        .rd_cls_o   (rd_cls),
        .rd_stamp_o (rd_stamp)
    );

    for (genvar q = 0; q < NQ; q++) begin : g_qry
        logic [LAT_W-1:0]  lat;
        logic [CNT_W-1:0]  age;
        logic [TAG_W-1:0]  qtag;
        logic [CCLS_W-1:0] qcls;

        assign qtag = qry_tag_i[q*TAG_W +: TAG_W];
        assign qcls = qry_cls_i[q*CCLS_W +: CCLS_W];

        lsb_lat_sel u_sel (
            .prod_i (rd_cls[q*PCLS_W +: PCLS_W]),
            .cons_i (qcls),
            .lat_o  (lat)
        );

        assign age          = cyc - rd_stamp[q*CNT_W +: CNT_W];
        assign qry_rdy_o[q] = !rd_pend[q] || (age >= CNT_W'(lat));

        // R2: no wait is shorter than two cycles
        a_r2_busy_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
            iss_vld_i |=> (qtag != $past(iss_tag_i)) || !qry_rdy_o[q]);

        // R10: readiness holds while the tag is not reissued
        a_r10_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (qry_rdy_o[q] && !(iss_vld_i && iss_tag_i == qtag)) |=>
            (qtag != $past(qtag)) || (qcls != $past(qcls)) || qry_rdy_o[q]);
    end

    assign cycle_o = cyc;

endmodule

// File: tb/dep_lat_scoreboard_tb_top.sv
module dep_lat_scoreboard_tb_top;

    localparam int NT = 32;
    localparam int TW = 5;
    localparam int CW = 6;
    localparam int NQ = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          iss_vld = 1'b0;
    logic [TW-1:0] iss_tag = '0;
    logic [3:0]    iss_cls = '0;
    logic [TW-1:0] qt0 = '0, qt1 = '0;
    logic [1:0]    qc0 = '0, qc1 = '0;
    logic [NQ-1:0] qry_rdy;
    logic [CW-1:0] cyc;

    dep_lat_scoreboard #(.NUM_TAGS(NT), .CNT_W(CW), .NQ(NQ)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .iss_vld_i (iss_vld),
        .iss_tag_i (iss_tag),
        .iss_cls_i (iss_cls),
        .qry_tag_i ({qt1, qt0}),
        .qry_cls_i ({qc1, qc0}),
        .qry_rdy_o (qry_rdy),
        .cycle_o   (cyc)
    );

    int    kind_q[$];
    int    port_q[$];
    int    exp_q[$];
    string req_q[$];

    int checks = 0;
    int bad    = 0;
    int now    = 0;
    bit done   = 1'b0;

    bit m_v[NT];
    int m_c[NT];
    int m_t[NT];

    function automatic int lat_of(int p, int c);
        case (p)
            0: return (c == 1) ? 4 : 2;
            1: return (c == 1) ? 5 : 3;
            2: return 4;
            3: return 7;
            4: return (c == 2) ? 4 : 5;
            5: return (c == 2) ? 4 : ((c == 1) ? 7 : 5);
            6: return 12;
            7: return (c == 1) ? 14 : 12;
            8: return (c == 3) ? 4 : 9;
            9: return 2;
            default: return 2;
        endcase
    endfunction

    function automatic string req_of(int p, int c);
        if ((p == 0 || p == 1) && c == 1)        return "R4";
        if ((p == 4 || p == 5) && c == 2)        return "R5";
        if (p == 5 && c == 1)                    return "R5";
        if (p == 6 || (p == 7 && c == 1))        return "R6";
        if (p == 8 && c == 3)                    return "R7";
        if (p == 3 || p == 9)                    return "R8";
        return "R3";
    endfunction

    function automatic int model_rdy(int tag, int c);
        if (!m_v[tag]) return 1;
        return ((now - m_t[tag]) >= lat_of(m_c[tag], c)) ? 1 : 0;
    endfunction

    task automatic push(int k, int p, int e, string r);
        kind_q.push_back(k);
        port_q.push_back(p);
        exp_q.push_back(e);
        req_q.push_back(r);
    endtask

    // one cycle: drive issue and both queries, queue expectations, update model
    task automatic step(bit iv, int it, int ic, int t0, int c0, int t1, int c1,
                        string r0, string r1);
        @(negedge clk);
        now++;
        iss_vld = iv;
        iss_tag = TW'(it);
        iss_cls = 4'(ic);
        qt0 = TW'(t0); qc0 = 2'(c0);
        qt1 = TW'(t1); qc1 = 2'(c1);
        push(0, 0, now % (1 << CW), "R1");
        push(1, 0, model_rdy(t0, c0), r0);
        push(1, 1, model_rdy(t1, c1), r1);
        if (iv) begin
            m_v[it] = 1'b1;
            m_c[it] = ic;
            m_t[it] = now;
        end
    endtask

    // issue then watch the tag for long enough to see it turn ready
    task automatic measure(int p, int c, int tag, int t1, int c1, string r1);
        step(1'b1, tag, p, tag, c, t1, c1, "R2", r1);
        for (int k = 1; k <= 16; k++) begin
            step(1'b0, 0, 0, tag, c, t1, c1, req_of(p, c), r1);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", checks, bad);
    endtask

    // monitor: compares every queued expectation after the inputs settle
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (kind_q.size() > 0) begin
                int    k, p, e, got;
                string r;
                k = kind_q.pop_front();
                p = port_q.pop_front();
                e = exp_q.pop_front();
                r = req_q.pop_front();
                got = (k == 0) ? int'(cyc) : int'(qry_rdy[p]);
                checks++;
                if (got != e) begin
                    bad++;
                    $display("FAIL %s kind %0d port %0d t=%0d: got %0d expected %0d",
                             r, k, p, now, got, e);
                end
            end
        end
    end

    initial begin
        repeat (6000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            bad++;
            $display("FAIL R1 watchdog: got no end expected end of run");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NT; i++) begin
            m_v[i] = 1'b0; m_c[i] = 0; m_t[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        now = 0;
        // R1: reset state
        push(0, 0, 0, "R1");
        push(1, 0, 1, "R1");
        push(1, 1, 1, "R1");
        step(1'b0, 0, 0, 7, 1, 30, 3, "R1", "R1");

        // R3..R8 every producer/consumer pair; port 1 watches another tag (R11)
        for (int p = 0; p < 16; p++) begin
            for (int c = 0; c < 4; c++) begin
                int tag;
                tag = (p * 4 + c) % NT;
                measure(p, c, tag, (tag + 17) % NT, (c + 1) % 4, "R11");
            end
        end

        // R9: reissue a pending long producer with a short one
        step(1'b1, 3, 6, 3, 0, 20, 0, "R9", "R11");
        step(1'b0, 0, 0, 3, 0, 20, 0, "R9", "R11");
        step(1'b1, 3, 0, 3, 0, 20, 0, "R9", "R11");
        for (int k = 0; k < 4; k++) step(1'b0, 0, 0, 3, 0, 20, 0, "R9", "R11");
        // R9: reissue a ready tag with a long producer
        step(1'b1, 3, 7, 3, 1, 3, 0, "R9", "R9");
        for (int k = 0; k < 16; k++) step(1'b0, 0, 0, 3, 1, 3, 0, "R9", "R9");

        // R11: same tag, different consumer classes on the two ports
        step(1'b1, 12, 5, 12, 2, 12, 1, "R11", "R11");
        for (int k = 0; k < 9; k++) step(1'b0, 0, 0, 12, 2, 12, 1, "R11", "R11");

        // R10: ready answers survive many counter wraps
        step(1'b1, 9, 0, 9, 1, 12, 1, "R10", "R10");
        for (int k = 0; k < 200; k++) step(1'b0, 0, 0, 9, 1, 12, 1, "R10", "R10");

        // R2: same-cycle issue and query of one tag, then busy next cycle
        step(1'b1, 9, 1, 9, 0, 9, 1, "R2", "R2");
        for (int k = 0; k < 6; k++) step(1'b0, 0, 0, 9, 0, 9, 1, "R2", "R2");

        @(negedge clk);
        #5;
        if (!done) begin
            done = 1'b1;
            summary();
            $finish;
        end
    end

endmodule